// File: doc/BRIEF.md
# Read Eye Training Engine

This block calibrates the read-capture delay of every byte lane of a memory data path. After a start pulse it loads a known test pattern into a small burst of memory locations, or skips that step and uses a fixed pattern source in the memory-access front end. It then sweeps a shared capture delay code from zero to its maximum. At each code it reads the burst back and notes, lane by lane, whether every returned beat matched the expected pattern.

Each lane keeps its own record of passing codes and retains the longest unbroken run. At the end the lane's delay is set to the centre of that run, optionally shifted by a guardband toward either end of the range. A lane that never passes is flagged. The engine talks to the front end through a single request port with a valid/ready handshake and takes back in-order read beats marked by a valid strobe.

Top module: `read_eye_trainer`

## Requirements
- R1: In normal mode the engine writes beats 0 to BEATS-1 (request command 0, address equals beat index, data from the pattern generator) before any read is issued.
- R2: Pattern select 0 gives all zeros and 1 gives all ones. Select 2 gives a checkerboard: even beats carry 0x55 in every byte and odd beats carry 0xAA. Select 3 gives a 16-bit LFSR with seed 0xACE1 that shifts left and takes bit 15 xor 13 xor 12 xor 10 into bit 0. Beat b carries the state after b steps, and word bit i is state bit i mod 16.
- R3: Read codes run from 0 to 2^DLY_W-1 in ascending unit steps, with exactly BEATS reads per code. While the engine is busy every lane's delay output equals the current code.
- R4: A lane passes a code only if all BEATS returned beats match the expected pattern in that lane's byte.
- R5: A lane's final delay is floor((first+last)/2) over the longest contiguous passing run. Among runs of equal length the lowest one wins.
- R6: With guardband enabled, the final delay moves up by the guardband amount (saturating at the top code), or down when the direction input is 1 (saturating at 0).
- R7: A lane with no passing code sets its error bit, and its delay output reads 0.
- R8: In predefined-source mode no write is issued, and every read uses command 2 instead of command 1.
- R9: Done rises only after all lanes have finished and busy has fallen. Done stays high until the next accepted start, and a start pulse while busy is ignored.
- R10: After reset, request valid, busy and done are low, and every delay output and error bit is 0.
- R11: Once a request is presented it stays valid with unchanged command and address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| pat_sel | input | 2 | Pattern select (R2 encoding) |
| pre_mode | input | 1 | 1: skip write phase, read from predefined source |
| guard_en | input | 1 | Apply guardband shift |
| guard_neg | input | 1 | Guardband direction, 1 = toward code 0 |
| guard_amt | input | GUARD_W | Guardband amount in codes |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Front end accepts request |
| req_cmd | output | 2 | 0 write, 1 read, 2 read predefined source |
| req_addr | output | BEAT_AW | Beat index |
| req_wdata | output | LANES*LANE_W | Write data |
| rsp_valid | input | 1 | Read beat returned |
| rsp_data | input | LANES*LANE_W | Returned read beat |
| lane_dly | output | LANES*DLY_W | Capture delay per lane, lane 0 in low bits |
| lane_err | output | LANES | No passing code found for lane |
| busy | output | 1 | Training in progress |
| done | output | 1 | Training finished |

## Verification
The bench builds the block with two 8-bit lanes, a 5-bit delay code (32 codes), four-beat bursts and a 3-bit guardband. With these values a full sweep takes a few hundred cycles, so many runs fit in one simulation. Both ends of the code range can be reached, either as window edges or as guardband saturation points. A 32-bit pass mask per lane lets the behavioural memory present split windows, equal-length ties, empty lanes and a single-beat glitch inside a window.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  localparam logic [1:0] CMD_WR    = 2'd0;
  localparam logic [1:0] CMD_RD    = 2'd1;
  localparam logic [1:0] CMD_RDPRE = 2'd2;

  typedef enum logic [1:0] {
    PAT_ZERO  = 2'd0,
    PAT_ONE   = 2'd1,
    PAT_CHECK = 2'd2,
    PAT_PRBS  = 2'd3
  } pat_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SCAN,
    ST_EVAL,
    ST_FIN
  } seq_st_e;

  localparam logic [15:0] PRBS_SEED = 16'hACE1;

  function automatic logic [15:0] prbs_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/rdt_patgen.sv
module rdt_patgen
  import rdt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [1:0]        sel,
  output logic [WORD_W-1:0] word
);

  logic [15:0] prbs_q, prbs_n;
  logic        odd_q, odd_n;

  always_comb begin
    prbs_n = prbs_q;
    odd_n  = odd_q;
    if (restart) begin
      prbs_n = PRBS_SEED;
      odd_n  = 1'b0;
    end else if (advance) begin
      prbs_n = prbs_step(prbs_q);
      odd_n  = ~odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prbs_q <= PRBS_SEED;
      odd_q  <= 1'b0;
    end else if (restart || advance) begin
      prbs_q <= prbs_n;
      odd_q  <= odd_n;
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      case (pat_e'(sel))
        PAT_ZERO:  word[i] = 1'b0;
        PAT_ONE:   word[i] = 1'b1;
        PAT_CHECK: word[i] = ((i % 2) == 0) ? ~odd_q : odd_q;
        default:   word[i] = prbs_q[i % 16];
      endcase
    end
  end

endmodule

// File: rtl/rdt_lane_track.sv
module rdt_lane_track #(
  parameter int DLY_W   = 5,
  parameter int GUARD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               upd,
  input  logic               pass,
  input  logic [DLY_W-1:0]   code,
  input  logic               fin,
  input  logic               guard_en,
  input  logic               guard_neg,
  input  logic [GUARD_W-1:0] guard_amt,
  output logic [DLY_W-1:0]   dly,
  output logic               err
);

  localparam int LEN_W = DLY_W + 1;
  localparam int SW    = DLY_W + GUARD_W + 2;
  localparam logic [SW-1:0] MAXC_W = SW'((1 << DLY_W) - 1);

  logic               in_run_q, in_run_n;
  logic [DLY_W-1:0]   cur_start_q, cur_start_n;
  logic [LEN_W-1:0]   cur_len_q, cur_len_n;
  logic [DLY_W-1:0]   best_start_q, best_start_n;
  logic [LEN_W-1:0]   best_len_q, best_len_n;
  logic [DLY_W-1:0]   dly_q, dly_n;
  logic               err_q, err_n;

  logic [LEN_W-1:0]   run_len_c;
  logic [DLY_W-1:0]   run_start_c;
  logic [SW-1:0]      first_w, last_w, mid_w, amt_w, up_w, adj_w;

  // running-window bookkeeping for the code being evaluated
  always_comb begin
    if (!pass)         run_len_c = '0;
    else if (in_run_q) run_len_c = cur_len_q + 1'b1;
    else               run_len_c = LEN_W'(1);
    run_start_c = (pass && !in_run_q) ? code : cur_start_q;
  end

  // centre of the best run, then guardband with saturation
  always_comb begin
    first_w = SW'(best_start_q);
    last_w  = first_w + SW'(best_len_q) - SW'(1);
    mid_w   = (first_w + last_w) >> 1;
    amt_w   = SW'(guard_amt);
    up_w    = mid_w + amt_w;
    if (!guard_en)      adj_w = mid_w;
    else if (guard_neg) adj_w = (mid_w < amt_w) ? '0 : (mid_w - amt_w);
    else                adj_w = (up_w > MAXC_W) ? MAXC_W : up_w;
  end

  always_comb begin
    in_run_n     = in_run_q;
    cur_start_n  = cur_start_q;
    cur_len_n    = cur_len_q;
    best_start_n = best_start_q;
    best_len_n   = best_len_q;
    dly_n        = dly_q;
    err_n        = err_q;
    if (clear) begin
      in_run_n     = 1'b0;
      cur_start_n  = '0;
      cur_len_n    = '0;
      best_start_n = '0;
      best_len_n   = '0;
      err_n        = 1'b0;
    end else if (upd) begin
      in_run_n    = pass;
      cur_len_n   = run_len_c;
      cur_start_n = run_start_c;
      if (run_len_c > best_len_q) begin
        best_len_n   = run_len_c;
        best_start_n = run_start_c;
      end
    end else if (fin) begin
      err_n = (best_len_q == '0);
      dly_n = (best_len_q == '0) ? '0 : adj_w[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run_q     <= 1'b0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
      dly_q        <= '0;
      err_q        <= 1'b0;
    end else if (clear || upd || fin) begin
      in_run_q     <= in_run_n;
      cur_start_q  <= cur_start_n;
      cur_len_q    <= cur_len_n;
      best_start_q <= best_start_n;
      best_len_q   <= best_len_n;
      dly_q        <= dly_n;
      err_q        <= err_n;
    end
  end

  assign dly = dly_q;
  assign err = err_q;

endmodule

// File: rtl/rdt_seq.sv
module rdt_seq
  import rdt_pkg::*;
#(
  parameter int BEAT_AW = 2,
  parameter int DLY_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               pre_mode,
  input  logic               req_ready,
  input  logic               rsp_valid,
  output logic               req_valid,
  output logic [1:0]         req_cmd,
  output logic [BEAT_AW-1:0] req_addr,
  output logic               busy,
  output logic               done,
  output logic               pre_run,
  output logic               gen_restart,
  output logic               gen_advance,
  output logic               trk_clear,
  output logic               trk_upd,
  output logic               trk_fin,
  output logic               rsp_take,
  output logic [DLY_W-1:0]   code
);

  localparam int CNT_W = BEAT_AW + 1;
  localparam logic [CNT_W-1:0] BEATS_C   = CNT_W'(1 << BEAT_AW);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'((1 << BEAT_AW) - 1);
  localparam logic [DLY_W-1:0] MAXC      = '1;

  seq_st_e          st_q, st_n;
  logic [CNT_W-1:0] iss_q, iss_n;
  logic [CNT_W-1:0] rsp_q, rsp_n;
  logic [DLY_W-1:0] code_q, code_n;
  logic             pre_q, pre_n;
  logic             done_q, done_n;

  always_comb begin
    st_n        = st_q;
    iss_n       = iss_q;
    rsp_n       = rsp_q;
    code_n      = code_q;
    pre_n       = pre_q;
    done_n      = done_q;
    req_valid   = 1'b0;
    req_cmd     = CMD_RD;
    gen_restart = 1'b0;
    gen_advance = 1'b0;
    trk_clear   = 1'b0;
    trk_upd     = 1'b0;
    trk_fin     = 1'b0;
    rsp_take    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          pre_n       = pre_mode;
          done_n      = 1'b0;
          trk_clear   = 1'b1;
          gen_restart = 1'b1;
          iss_n       = '0;
          rsp_n       = '0;
          code_n      = '0;
          st_n        = pre_mode ? ST_SCAN : ST_WRITE;
        end
      end
      ST_WRITE: begin
        req_valid = 1'b1;
        req_cmd   = CMD_WR;
        if (req_ready) begin
          if (iss_q == LAST_BEAT) begin
            iss_n       = '0;
            gen_restart = 1'b1;
            st_n        = ST_SCAN;
          end else begin
            iss_n       = iss_q + 1'b1;
            gen_advance = 1'b1;
          end
        end
      end
      ST_SCAN: begin
        req_valid = (iss_q < BEATS_C);
        req_cmd   = pre_q ? CMD_RDPRE : CMD_RD;
        if (req_valid && req_ready) iss_n = iss_q + 1'b1;
        if (rsp_valid) begin
          rsp_take    = 1'b1;
          gen_advance = 1'b1;
          rsp_n       = rsp_q + 1'b1;
          if (rsp_q == LAST_BEAT) st_n = ST_EVAL;
        end
      end
      ST_EVAL: begin
        trk_upd = 1'b1;
        if (code_q == MAXC) begin
          st_n = ST_FIN;
        end else begin
          code_n      = code_q + 1'b1;
          iss_n       = '0;
          rsp_n       = '0;
          gen_restart = 1'b1;
          st_n        = ST_SCAN;
        end
      end
      ST_FIN: begin
        trk_fin = 1'b1;
        done_n  = 1'b1;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iss_q  <= '0;
      rsp_q  <= '0;
      code_q <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      iss_q  <= iss_n;
      rsp_q  <= rsp_n;
      code_q <= code_n;
      pre_q  <= pre_n;
      done_q <= done_n;
    end
  end

  assign req_addr = iss_q[BEAT_AW-1:0];
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign pre_run  = pre_q;
  assign code     = code_q;

endmodule

// File: rtl/read_eye_trainer.sv
module read_eye_trainer
  import rdt_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int DLY_W   = 5,
  parameter int BEAT_AW = 2,
  parameter int GUARD_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [1:0]               pat_sel,
  input  logic                     pre_mode,
  input  logic                     guard_en,
  input  logic                     guard_neg,
  input  logic [GUARD_W-1:0]       guard_amt,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [1:0]               req_cmd,
  output logic [BEAT_AW-1:0]       req_addr,
  output logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic                     rsp_valid,
  input  logic [LANES*LANE_W-1:0]  rsp_data,
  output logic [LANES*DLY_W-1:0]   lane_dly,
  output logic [LANES-1:0]         lane_err,
  output logic                     busy,
  output logic                     done
);

  localparam int WORD_W = LANES * LANE_W;

  logic               gen_restart, gen_advance;
  logic               trk_clear, trk_upd, trk_fin, rsp_take;
  logic               pre_run;
  logic [DLY_W-1:0]   code;
  logic [WORD_W-1:0]  exp_word;

  // run configuration captured at start
  logic [1:0]         sel_q;
  logic               gen_q, neg_q;
  logic [GUARD_W-1:0] amt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      gen_q <= 1'b0;
      neg_q <= 1'b0;
      amt_q <= '0;
    end else if (trk_clear) begin
      sel_q <= pat_sel;
      gen_q <= guard_en;
      neg_q <= guard_neg;
      amt_q <= guard_amt;
    end
  end

  rdt_seq #(
    .BEAT_AW (BEAT_AW),
    .DLY_W   (DLY_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pre_mode    (pre_mode),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_addr    (req_addr),
    .busy        (busy),
    .done        (done),
    .pre_run     (pre_run),
    .gen_restart (gen_restart),
    .gen_advance (gen_advance),
    .trk_clear   (trk_clear),
    .trk_upd     (trk_upd),
    .trk_fin     (trk_fin),
    .rsp_take    (rsp_take),
    .code        (code)
  );

  rdt_patgen #(
    .WORD_W (WORD_W)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (gen_restart),
    .advance (gen_advance),
    .sel     (sel_q),
    .word    (exp_word)
  );

  assign req_wdata = exp_word;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic             ok_q, ok_n;
    logic [DLY_W-1:0] trk_dly;
    logic             trk_err;

    always_comb begin
      ok_n = ok_q;
      if (gen_restart)   ok_n = 1'b1;
      else if (rsp_take) ok_n = ok_q &
        (rsp_data[l*LANE_W +: LANE_W] == exp_word[l*LANE_W +: LANE_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ok_q <= 1'b0;
      else if (gen_restart || rsp_take) ok_q <= ok_n;
    end

    rdt_lane_track #(
      .DLY_W   (DLY_W),
      .GUARD_W (GUARD_W)
    ) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (trk_clear),
      .upd       (trk_upd),
      .pass      (ok_q),
      .code      (code),
      .fin       (trk_fin),
      .guard_en  (gen_q),
      .guard_neg (neg_q),
      .guard_amt (amt_q),
      .dly       (trk_dly),
      .err       (trk_err)
    );

    assign lane_dly[l*DLY_W +: DLY_W] = busy ? code : trk_dly;
    assign lane_err[l]                = trk_err;
  end

endmodule

// File: rtl/rdt_chk.sv
module rdt_chk #(
  parameter int LANES   = 2,
  parameter int DLY_W   = 5,
  parameter int BEAT_AW = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [1:0]             req_cmd,
  input logic [BEAT_AW-1:0]     req_addr,
  input logic                   busy,
  input logic                   done,
  input logic                   pre_run,
  input logic [LANES*DLY_W-1:0] lane_dly,
  input logic [LANES-1:0]       lane_err
);

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_cmd) && $stable(req_addr));

  assert_no_write_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && pre_run && req_valid |-> req_cmd == 2'd2);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_code_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> lane_dly[DLY_W-1:0] >= $past(lane_dly[DLY_W-1:0]));

  for (genvar l = 0; l < LANES; l++) begin : g_err
    assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && lane_err[l] |-> lane_dly[l*DLY_W +: DLY_W] == '0);
  end

endmodule

bind read_eye_trainer rdt_chk #(
  .LANES   (LANES),
  .DLY_W   (DLY_W),
  .BEAT_AW (BEAT_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .req_addr  (req_addr),
  .busy      (busy),
  .done      (done),
  .pre_run   (pre_run),
  .lane_dly  (lane_dly),
  .lane_err  (lane_err)
);

// File: tb/sim_read_eye_trainer.sv
`timescale 1ns/1ps
module sim_read_eye_trainer;

  localparam int LANES = 2, LANE_W = 8, DLY_W = 5, BEAT_AW = 2, GUARD_W = 3;
  localparam int BEATS = 4, NCODE = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic start, pre_mode, guard_en, guard_neg;
  logic [1:0] pat_sel;
  logic [GUARD_W-1:0] guard_amt;
  logic req_valid, req_ready;
  logic [1:0] req_cmd;
  logic [BEAT_AW-1:0] req_addr;
  logic [15:0] req_wdata;
  logic rsp_valid;
  logic [15:0] rsp_data;
  logic [LANES*DLY_W-1:0] lane_dly;
  logic [LANES-1:0] lane_err;
  logic busy, done;

  always #2.5 clk = ~clk;

  read_eye_trainer #(.LANES(LANES), .LANE_W(LANE_W), .DLY_W(DLY_W),
                     .BEAT_AW(BEAT_AW), .GUARD_W(GUARD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel),
    .pre_mode(pre_mode), .guard_en(guard_en), .guard_neg(guard_neg),
    .guard_amt(guard_amt), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .lane_dly(lane_dly),
    .lane_err(lane_err), .busy(busy), .done(done));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mask [LANES];
  logic [15:0] mem [BEATS];
  int wr_cnt, rd_cnt, badcmd, order_bad, last_code, run_sel, glitch_code;
  logic [1:0] exp_cmd;
  bit rdy_rand = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat_word(input int sel, input int beat);
    logic [15:0] s = 16'hACE1;
    case (sel)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return (beat % 2) ? 16'hAAAA : 16'h5555;
      default: begin
        for (int k = 0; k < beat; k++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return s;
      end
    endcase
  endfunction

  function automatic int exp_dly(input logic [31:0] m, input bit en, input bit neg,
                                 input int amt, output bit err);
    int bs = 0, bl = 0, cs = 0, cl = 0, mid;
    for (int c = 0; c < NCODE; c++) begin
      if (m[c]) begin
        if (cl == 0) cs = c;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    err = (bl == 0);
    if (err) return 0;
    mid = (bs + bs + bl - 1) / 2;
    if (en) mid = neg ? ((mid < amt) ? 0 : mid - amt) : ((mid + amt > NCODE - 1) ? NCODE - 1 : mid + amt);
    return mid;
  endfunction

  always @(negedge clk) req_ready <= rdy_rand ? (($urandom % 3) != 0) : 1'b1;

  // behavioural memory with per-lane pass mask over the delay code
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        if (req_cmd == 2'd0) begin
          mem[req_addr] <= req_wdata;
          wr_cnt++;
        end else begin
          logic [15:0] w;
          int cd;
          cd = int'(lane_dly[4:0]);
          rd_cnt++;
          if (req_cmd != exp_cmd) badcmd++;
          if (int'(lane_dly[9:5]) != cd) order_bad++;
          if (rd_cnt == 1) begin
            if (cd != 0) order_bad++;
          end else if (cd != last_code && cd != last_code + 1) order_bad++;
          last_code = cd;
          w = (req_cmd == 2'd1) ? mem[req_addr] : pat_word(run_sel, int'(req_addr));
          for (int l = 0; l < LANES; l++)
            if (!mask[l][cd]) w[l*8 +: 8] = w[l*8 +: 8] ^ 8'hFF;
          if (cd == glitch_code && req_addr == 2'd3) w[7:0] = w[7:0] ^ 8'h01;
          rsp_valid <= 1'b1;
          rsp_data  <= w;
        end
      end
    end
  end

  task automatic run(input int sel, input bit pre, input bit gen, input bit neg,
                     input int amt, input bit rr, input bit poke, input string tag);
    int n = 0;
    logic [31:0] m0;
    bit e;
    int d;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; badcmd = 0; order_bad = 0; last_code = 0;
    run_sel = sel; exp_cmd = pre ? 2'd2 : 2'd1; rdy_rand = rr;
    pat_sel = 2'(sel); pre_mode = pre; guard_en = gen; guard_neg = neg;
    guard_amt = GUARD_W'(amt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R9 busy set and done cleared after start", int'({busy, done}), 2);
    if (poke) begin
      repeat (40) @(negedge clk);
      pat_sel = ~pat_sel; pre_mode = ~pre; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(n < 20000, "R9 run finished (watchdog)", n, 0);
    check(done && !busy && !req_valid, "R9 done with busy low", int'({done, busy, req_valid}), 4);
    for (int l = 0; l < LANES; l++) begin
      m0 = mask[l];
      if (l == 0 && glitch_code >= 0) m0[glitch_code] = 1'b0;
      d = exp_dly(m0, gen, neg, amt, e);
      check(lane_err[l] == e, $sformatf("R7 lane %0d error flag", l), int'(lane_err[l]), int'(e));
      check(int'(lane_dly[l*DLY_W +: DLY_W]) == d, $sformatf("%s lane %0d delay", tag, l),
            int'(lane_dly[l*DLY_W +: DLY_W]), d);
    end
    check(wr_cnt == (pre ? 0 : BEATS), pre ? "R8 no writes" : "R1 write count", wr_cnt, pre ? 0 : BEATS);
    check(rd_cnt == NCODE * BEATS, "R3 read count", rd_cnt, NCODE * BEATS);
    check(order_bad == 0, "R3 code order", order_bad, 0);
    check(badcmd == 0, "R8 read command type", badcmd, 0);
    if (!pre)
      for (int b = 0; b < BEATS; b++)
        check(mem[b] == pat_word(sel, b), $sformatf("R2 pattern %0d beat %0d", sel, b),
              int'(mem[b]), int'(pat_word(sel, b)));
  endtask

  function automatic logic [31:0] win(input int lo, input int hi);
    logic [31:0] r = '0;
    for (int c = lo; c <= hi; c++) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    glitch_code = -1;
    rst_n = 1'b0; start = 1'b0; pat_sel = '0; pre_mode = 1'b0;
    guard_en = 1'b0; guard_neg = 1'b0; guard_amt = '0;
    mask[0] = '0; mask[1] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !req_valid, "R10 idle after reset", int'({busy, done, req_valid}), 0);
    check(lane_dly == '0, "R10 delays zero after reset", int'(lane_dly), 0);
    check(lane_err == '0, "R10 errors clear after reset", int'(lane_err), 0);

    // R5 simple windows, LFSR pattern
    mask[0] = win(5, 12); mask[1] = win(10, 20);
    run(3, 0, 0, 0, 0, 0, 0, "R5");
    // R5 longest run wins, tie goes to the lower run; checkerboard
    mask[0] = win(2, 4) | win(10, 17); mask[1] = win(3, 6) | win(20, 23);
    run(2, 0, 0, 0, 0, 1, 0, "R5");
    // R7 lane with no passing code; all-ones pattern
    mask[0] = win(0, 31); mask[1] = '0;
    run(1, 0, 0, 0, 0, 0, 0, "R5");
    // R6 guardband saturating high and low
    mask[0] = win(28, 31); mask[1] = win(0, 3);
    run(0, 0, 1, 0, 3, 0, 0, "R6");
    run(3, 0, 1, 1, 3, 1, 0, "R6");
    // R8 predefined source; R9 start while busy ignored
    mask[0] = win(7, 9); mask[1] = win(0, 31);
    run(2, 1, 0, 0, 0, 1, 1, "R5");
    // R4 one bad beat inside the window splits it
    glitch_code = 12;
    mask[0] = win(8, 20); mask[1] = win(1, 2);
    run(3, 0, 0, 0, 0, 0, 0, "R4");
    glitch_code = -1;

    for (int t = 0; t < 12; t++) begin
      for (int l = 0; l < LANES; l++) begin
        int lo = $urandom % 32, hi;
        hi = lo + ($urandom % (32 - lo));
        case ($urandom % 4)
          0: mask[l] = '0;
          1: mask[l] = win(lo, hi);
          2: mask[l] = win(lo, hi) | win($urandom % 8, $urandom % 8 + 2);
          default: mask[l] = $urandom;
        endcase
      end
      run($urandom % 4, 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom % 8, 1'($urandom), 0, "R6");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule